// File: doc/BRIEF.md
# Channel Scan and Interval Pacing Sequencer

This block decides which input channel each analog-to-digital conversion samples and whether conversions may run at all. It either keeps one fixed channel for the whole acquisition, or walks downward from a programmed top channel to channel 0 and then starts again at the top. The channel moves to its next value when a conversion pulse ends. The next channel is therefore settled before the following conversion begins.

A pacing stage gates the conversions with a single enable output. In free-run pacing the enable is always high. In scan-interval pacing each complete pass of the channel walk must wait for an interval tick. In burst-interval pacing a sample count is kept in a holding register. An arm strobe copies that count into a down-counter. Conversions then run until the counter reaches zero, and each later interval tick reloads the counter from the holding register. A tick that arrives while a pass or burst is still running is dropped and sets a sticky missed-tick flag.

The start channel is loaded by a configuration write with scanning cleared. A second write with the same channel and scanning set then enables the walk without moving the current channel.

Top module: `acq_chan_sequencer`

## Requirements
- R1: After reset the channel output is 0, pacing is free-run with scanning off, the missed-tick flag is 0 and the convert enable is 1.
- R2: A configuration write with scan cleared loads the written value into the channel output on the next cycle. With scan off, the channel stays at that value across any number of conversions.
- R3: With scan set, each completed conversion moves the channel from c to c-1. From 0 it moves to the programmed top channel, so for top T the channel after k conversions is T - (k mod (T+1)).
- R4: The channel changes only on the clock edge that first samples the conversion pulse low after it was high. It does not change while the pulse is still high.
- R5: Pacing code 01 (scan-interval): after a configuration write the enable is 0, and conversions that end while it is 0 do not move the channel. The enable rises after an interval tick and falls after the conversion that ends at channel 0.
- R6: In scan-interval pacing with scan off, every single conversion counts as a full pass and drops the enable.
- R7: Pacing code 10 (burst-interval): a count written to the holding register has no effect until the arm strobe. After arming, the enable stays high for exactly that many conversions and then falls. Each later tick reloads the same count.
- R8: A burst count of 0 keeps the enable low after arming and after any tick.
- R9: A tick that arrives during a running pass or burst neither restarts nor reloads it. It sets the missed-tick flag, which stays set until the next configuration write clears it.
- R10: Pacing codes 00 and 11 are free-run: the enable is 1 regardless of ticks.
- R11: In burst-interval pacing a tick before the first arm strobe is ignored: the enable stays 0 and no missed tick is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_chan | input | CH_W | Channel value (top or fixed channel) |
| cfg_scan | input | 1 | Scan enable written with the configuration |
| cfg_pace | input | 2 | Pacing code: 00 free, 01 scan-interval, 10 burst-interval, 11 free |
| conv_pulse | input | 1 | Conversion pulse; its falling edge completes a conversion |
| intv_tick | input | 1 | Interval tick, one cycle wide |
| burst_we | input | 1 | Write strobe for the burst holding register |
| burst_val | input | CNT_W | Burst sample count |
| burst_arm | input | 1 | Copies the holding register into the burst counter and arms it |
| chan_out | output | CH_W | Channel selected for the next conversion |
| conv_en | output | 1 | Conversions permitted |
| tick_missed | output | 1 | Sticky flag: a tick came during a running pass or burst |

## Verification
The bench builds the block with a 3-bit channel field and a 4-bit burst counter. With these sizes every top channel from 0 to 7 can be walked through two full wraps, and burst counts from 0 to 5 can be tried, including the empty burst. The expected channel comes from the modular formula in R3, and the expected enable comes from counting conversions against the burst length. The small counter width also makes it cheap to test ticks that land mid-pass, mid-burst and before arming, as well as a pulse held high across several edges.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;
   typedef enum logic [1:0] {
      PACE_FREE  = 2'b00,
      PACE_SCAN  = 2'b01,
      PACE_BURST = 2'b10,
      PACE_RSVD  = 2'b11
   } pace_e;
endpackage

// File: rtl/trail_edge_det.sv
module trail_edge_det (
   input  logic clk,
   input  logic rst_n,
   input  logic pulse_in,
   output logic fall_o
);
   logic pulse_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= pulse_in;
   end

   assign fall_o = pulse_q & ~pulse_in;

   // R4
   fall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |=> !fall_o);
endmodule

// File: rtl/chan_walker.sv
module chan_walker #(
   parameter int CH_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_i,
   input  logic [CH_W-1:0] load_val_i,
   input  logic [CH_W-1:0] top_i,
   input  logic            scan_i,
   input  logic            step_i,
   output logic [CH_W-1:0] chan_o,
   output logic            at_bottom_o
);
   localparam logic [CH_W-1:0] CH_ZERO = '0;
   localparam logic [CH_W-1:0] CH_ONE  = CH_W'(1);

   initial begin
      param_chk: assert (CH_W >= 1 && CH_W <= 8)
         else $error("chan_walker: CH_W out of range");
   end

   logic [CH_W-1:0] chan_q;
   logic [CH_W-1:0] chan_nxt;

   always_comb begin
      chan_nxt = chan_q;
      if (load_i)
         chan_nxt = load_val_i;
      else if (step_i && scan_i)
         chan_nxt = (chan_q == CH_ZERO) ? top_i : (chan_q - CH_ONE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chan_q <= CH_ZERO;
      else        chan_q <= chan_nxt;
   end

   assign chan_o      = chan_q;
   assign at_bottom_o = (chan_q == CH_ZERO);

   // R3
   scan_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_i && scan_i && !load_i && chan_q != CH_ZERO |=> chan_q == $past(chan_q) - CH_ONE);
   // R3
   scan_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_i && scan_i && !load_i && chan_q == CH_ZERO |=> chan_q == $past(top_i));
   // R2
   hold_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i && !(step_i && scan_i) |=> $stable(chan_q));
endmodule

// File: rtl/pace_ctrl.sv
module pace_ctrl
   import acq_seq_pkg::*;
#(
   parameter int CNT_W     = 8,
   parameter bit HAS_BURST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  pace_e            pace_i,
   input  logic             restart_i,
   input  logic             step_i,
   input  logic             pass_done_i,
   input  logic             tick_i,
   input  logic             hold_we_i,
   input  logic [CNT_W-1:0] hold_val_i,
   input  logic             arm_i,
   output logic             conv_en_o,
   output logic             missed_o
);
   localparam logic [CNT_W-1:0] CNT_ZERO = '0;
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   initial begin
      param_chk: assert (CNT_W >= 1 && CNT_W <= 32)
         else $error("pace_ctrl: CNT_W out of range");
   end

   logic scan_active_q;
   logic scan_miss;
   logic burst_miss;
   logic burst_en;
   logic missed_q;

   // scan-interval pass gate
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         scan_active_q <= 1'b0;
      else if (restart_i)
         scan_active_q <= 1'b0;
      else if (pace_i == PACE_SCAN) begin
         if (scan_active_q) begin
            if (pass_done_i) scan_active_q <= 1'b0;
         end else if (tick_i)
            scan_active_q <= 1'b1;
      end
   end

   assign scan_miss = (pace_i == PACE_SCAN) && scan_active_q && tick_i;

   generate
      if (HAS_BURST) begin : g_burst
         logic [CNT_W-1:0] hold_q;
         logic [CNT_W-1:0] cnt_q;
         logic             armed_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         hold_q <= CNT_ZERO;
            else if (hold_we_i) hold_q <= hold_val_i;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q   <= CNT_ZERO;
               armed_q <= 1'b0;
            end else if (restart_i) begin
               cnt_q   <= CNT_ZERO;
               armed_q <= 1'b0;
            end else if (pace_i == PACE_BURST) begin
               if (arm_i) begin
                  cnt_q   <= hold_q;
                  armed_q <= 1'b1;
               end else if (armed_q) begin
                  if (cnt_q != CNT_ZERO) begin
                     if (step_i) cnt_q <= cnt_q - CNT_ONE;
                  end else if (tick_i)
                     cnt_q <= hold_q;
               end
            end
         end

         assign burst_en   = armed_q && (cnt_q != CNT_ZERO);
         assign burst_miss = (pace_i == PACE_BURST) && !arm_i && armed_q &&
                             (cnt_q != CNT_ZERO) && tick_i;

         // R7
         burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pace_i == PACE_BURST && !restart_i && !arm_i && step_i && cnt_q == CNT_ONE
            |=> !conv_en_o);
         // R8
         burst_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pace_i == PACE_BURST && !restart_i && arm_i && hold_q == CNT_ZERO
            |=> !conv_en_o);
      end else begin : g_noburst
         assign burst_en   = 1'b0;
         assign burst_miss = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       missed_q <= 1'b0;
      else if (restart_i)               missed_q <= 1'b0;
      else if (scan_miss || burst_miss) missed_q <= 1'b1;
   end

   always_comb begin
      unique case (pace_i)
         PACE_SCAN:  conv_en_o = scan_active_q;
         PACE_BURST: conv_en_o = burst_en;
         default:    conv_en_o = 1'b1;
      endcase
   end

   assign missed_o = missed_q;

   // R5
   pass_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pace_i == PACE_SCAN && !restart_i && conv_en_o && pass_done_i |=> !conv_en_o);
   // R9
   scan_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pace_i == PACE_SCAN && !restart_i && conv_en_o && tick_i |=> missed_o);
   // R9
   miss_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      missed_o && !restart_i |=> missed_o);
   // R10
   free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pace_i == PACE_FREE || pace_i == PACE_RSVD) |-> conv_en_o);
endmodule

// File: rtl/acq_chan_sequencer.sv
module acq_chan_sequencer
   import acq_seq_pkg::*;
#(
   parameter int CH_W      = 3,
   parameter int CNT_W     = 8,
   parameter bit HAS_BURST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [CH_W-1:0]  cfg_chan,
   input  logic             cfg_scan,
   input  logic [1:0]       cfg_pace,
   input  logic             conv_pulse,
   input  logic             intv_tick,
   input  logic             burst_we,
   input  logic [CNT_W-1:0] burst_val,
   input  logic             burst_arm,
   output logic [CH_W-1:0]  chan_out,
   output logic             conv_en,
   output logic             tick_missed
);
   logic [CH_W-1:0] top_q;
   logic            scan_q;
   pace_e           pace_q;
   logic            fall;
   logic            step;
   logic            at_bottom;
   logic            pass_done;
   logic            load_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         top_q  <= '0;
         scan_q <= 1'b0;
         pace_q <= PACE_FREE;
      end else if (cfg_we) begin
         top_q  <= cfg_chan;
         scan_q <= cfg_scan;
         pace_q <= pace_e'(cfg_pace);
      end
   end

   trail_edge_det u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .pulse_in (conv_pulse),
      .fall_o   (fall)
   );

   assign step       = fall && conv_en;
   assign load_start = cfg_we && !cfg_scan;
   assign pass_done  = step && (!scan_q || at_bottom);

   chan_walker #(.CH_W(CH_W)) u_walk (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (load_start),
      .load_val_i  (cfg_chan),
      .top_i       (top_q),
      .scan_i      (scan_q),
      .step_i      (step),
      .chan_o      (chan_out),
      .at_bottom_o (at_bottom)
   );

   pace_ctrl #(.CNT_W(CNT_W), .HAS_BURST(HAS_BURST)) u_pace (
      .clk         (clk),
      .rst_n       (rst_n),
      .pace_i      (pace_q),
      .restart_i   (cfg_we),
      .step_i      (step),
      .pass_done_i (pass_done),
      .tick_i      (intv_tick),
      .hold_we_i   (burst_we),
      .hold_val_i  (burst_val),
      .arm_i       (burst_arm),
      .conv_en_o   (conv_en),
      .missed_o    (tick_missed)
   );

   // R2
   start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we && !cfg_scan |=> chan_out == $past(cfg_chan));
   // R5
   idle_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_en && !cfg_we |=> $stable(chan_out));
endmodule

// File: tb/tb_acq_chan_sequencer.sv
module tb_acq_chan_sequencer;
   localparam int CH_W  = 3;
   localparam int CNT_W = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_we = 1'b0;
   logic [CH_W-1:0]  cfg_chan = '0;
   logic             cfg_scan = 1'b0;
   logic [1:0]       cfg_pace = 2'b00;
   logic             conv_pulse = 1'b0;
   logic             intv_tick = 1'b0;
   logic             burst_we = 1'b0;
   logic [CNT_W-1:0] burst_val = '0;
   logic             burst_arm = 1'b0;
   logic [CH_W-1:0]  chan_out;
   logic             conv_en;
   logic             tick_missed;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   acq_chan_sequencer #(.CH_W(CH_W), .CNT_W(CNT_W)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_chan(cfg_chan),
      .cfg_scan(cfg_scan), .cfg_pace(cfg_pace), .conv_pulse(conv_pulse),
      .intv_tick(intv_tick), .burst_we(burst_we), .burst_val(burst_val),
      .burst_arm(burst_arm), .chan_out(chan_out), .conv_en(conv_en),
      .tick_missed(tick_missed)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cfg(input int ch, input bit sc, input int pace);
      @(negedge clk);
      cfg_we = 1'b1; cfg_chan = CH_W'(ch); cfg_scan = sc; cfg_pace = 2'(pace);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic pulse();
      @(negedge clk); conv_pulse = 1'b1;
      @(negedge clk); conv_pulse = 1'b0;
      @(negedge clk);
   endtask

   task automatic tick();
      @(negedge clk); intv_tick = 1'b1;
      @(negedge clk); intv_tick = 1'b0;
   endtask

   task automatic arm(input int n);
      @(negedge clk); burst_we = 1'b1; burst_val = CNT_W'(n);
      @(negedge clk); burst_we = 1'b0; burst_arm = 1'b1;
      @(negedge clk); burst_arm = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 chan", int'(chan_out), 0);
      chk("R1 en", int'(conv_en), 1);
      chk("R1 missed", int'(tick_missed), 0);
      // R10 free run ignores ticks
      tick();
      chk("R10 en after tick", int'(conv_en), 1);
      chk("R10 missed", int'(tick_missed), 0);

      // R2 fixed channel
      cfg(5, 1'b0, 0);
      chk("R2 load", int'(chan_out), 5);
      for (int i = 0; i < 3; i++) begin
         pulse();
         chk("R2 hold", int'(chan_out), 5);
      end

      // R3 sweep all tops, two wraps each
      for (int t = 0; t < 8; t++) begin
         cfg(t, 1'b0, 0);
         cfg(t, 1'b1, 0);
         chk("R3 start", int'(chan_out), t);
         for (int k = 1; k <= 2 * (t + 1); k++) begin
            pulse();
            chk("R3 walk", int'(chan_out), t - (k % (t + 1)));
         end
      end

      // R4 trailing edge timing, pulse held high several edges
      cfg(3, 1'b0, 3);
      cfg(3, 1'b1, 3);
      @(negedge clk); conv_pulse = 1'b1;
      repeat (3) begin
         @(negedge clk);
         chk("R4 stable while high", int'(chan_out), 3);
      end
      conv_pulse = 1'b0;
      chk("R4 before fall edge", int'(chan_out), 3);
      @(negedge clk);
      chk("R4 after fall edge", int'(chan_out), 2);
      chk("R10 rsvd code en", int'(conv_en), 1);

      // R5 scan-interval pacing
      cfg(2, 1'b0, 1);
      cfg(2, 1'b1, 1);
      chk("R5 idle en", int'(conv_en), 0);
      pulse();
      chk("R5 idle no step", int'(chan_out), 2);
      tick();
      chk("R5 en after tick", int'(conv_en), 1);
      pulse(); chk("R5 ch1", int'(chan_out), 1); chk("R5 en mid", int'(conv_en), 1);
      // R9 tick mid pass
      tick();
      chk("R9 missed set", int'(tick_missed), 1);
      chk("R9 pass not restarted", int'(chan_out), 1);
      pulse(); chk("R5 ch0", int'(chan_out), 0); chk("R5 en at 0", int'(conv_en), 1);
      pulse(); chk("R5 wrap", int'(chan_out), 2); chk("R5 en off", int'(conv_en), 0);
      chk("R9 missed sticky", int'(tick_missed), 1);
      tick();
      chk("R5 next pass", int'(conv_en), 1);
      cfg(2, 1'b1, 1);
      chk("R9 missed cleared", int'(tick_missed), 0);

      // R6 scan off in scan-interval pacing
      cfg(4, 1'b0, 1);
      tick();
      chk("R6 en", int'(conv_en), 1);
      pulse();
      chk("R6 en off", int'(conv_en), 0);
      chk("R6 chan", int'(chan_out), 4);

      // R11 tick before arming
      cfg(1, 1'b0, 2);
      tick();
      chk("R11 en", int'(conv_en), 0);
      chk("R11 missed", int'(tick_missed), 0);

      // R7 / R8 burst sweep
      for (int n = 0; n < 6; n++) begin
         cfg(1, 1'b0, 2);
         @(negedge clk); burst_we = 1'b1; burst_val = CNT_W'(n);
         @(negedge clk); burst_we = 1'b0;
         chk("R7 no effect before arm", int'(conv_en), 0);
         @(negedge clk); burst_arm = 1'b1;
         @(negedge clk); burst_arm = 1'b0;
         for (int rnd = 0; rnd < 2; rnd++) begin
            for (int k = 0; k < n + 1; k++) begin
               chk(n == 0 ? "R8 empty burst" : "R7 burst en", int'(conv_en), (k < n) ? 1 : 0);
               pulse();
            end
            chk("R7 burst done", int'(conv_en), 0);
            tick();
            chk(n == 0 ? "R8 tick empty" : "R7 reload", int'(conv_en), (n > 0) ? 1 : 0);
         end
         chk("R8 no missed", int'(tick_missed), 0);
      end

      // R9 burst tick mid run
      cfg(1, 1'b0, 2);
      arm(3);
      pulse();
      tick();
      chk("R9 burst missed", int'(tick_missed), 1);
      pulse(); chk("R9 burst not reloaded a", int'(conv_en), 1);
      pulse(); chk("R9 burst not reloaded b", int'(conv_en), 0);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule